// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte type-0 configuration header of a single device function. A small address router sits in front of it. A configuration request carries a 24-bit address. The upper two bytes select a bus and a device/function. The low byte is a byte offset into the header. A request of byte, word or dword size that selects this function reads or writes the header. A request that selects anything else reads back all ones, and its write data is dropped.

Writes are filtered one byte at a time. Identity, class, header-type, base-address, subsystem and interrupt-pin bytes cannot be changed by generic writes. Reserved command bits never store. A dword write that lands on an implemented base-address register (BAR) or on the expansion-ROM register is handled by a separate path. That path clears the bits below the region size and applies the fixed type bit or the enable bit. Software can therefore size a region by writing all ones and reading the result back.

Each request gets a registered response one cycle later. A write that reaches the command register also raises a one-cycle strobe, so that a downstream address decoder can re-evaluate its windows.

Top module: `cfg_hdr_regs`

## Requirements
- R1: A request is matched when address bits 23:16 equal `BUS_NUM` and bits 15:8 equal `DEVFN`; bits 7:0 are the offset. `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low during and right after reset.
- R2: A read that misses returns 0xFF, 0xFFFF or 0xFFFFFFFF for size codes 0, 1 and 2/3, with the unused upper bits zero. A write that misses changes no byte.
- R3: A read returns bytes little-endian, starting at the offset (lane n = offset+n). Size code 0 is byte, 1 is word, 2 and 3 are dword. A dword is returned only at offsets up to 0xFC, and a word only up to 0xFE. Past those limits the read falls back to word (dword at 0xFD/0xFE) or to a single byte (at 0xFF). Write responses carry zero data.
- R4: After reset the header holds: vendor ID at 0x00–0x01, device ID at 0x02–0x03, revision at 0x08, class at 0x09–0x0B, 0x00 at 0x0E, subsystem vendor and device IDs at 0x2C–0x2F, interrupt pin at 0x3D, bit 0 of each implemented BAR equal to its I/O flag, and zero in every other byte. All values are little-endian.
- R5: Generic writes leave these bytes unchanged: 0x3D, 0x2C–0x33, 0x10–0x27, 0x0E, 0x06–0x0B, 0x00–0x03. Every other byte stores the written data.
- R6: At offset 0x05 (upper command byte) only bits 2:0 store; bits 7:3 are always written as zero.
- R7: A generic write of size code 0, 1 or 2/3 covers 1, 2 or 4 consecutive bytes starting at the offset, with lane n going to offset+n. Bytes that would fall past 0xFF are dropped, not wrapped.
- R8: A dword write whose offset lies in 0x10–0x27 targets BAR n = (offset−0x10)/4. The register is always at its aligned offset. If BAR n is implemented with size 2^k, the register stores (data with bits k−1:0 cleared) OR its I/O flag in bit 0. Writing all ones therefore reads back the size mask. Unimplemented BARs stay zero.
- R9: A dword write whose offset lies in 0x30–0x33 stores, into the ROM register, the data with bits k−1:0 cleared except bit 0, the enable bit, which stores as written.
- R10: `cmd_touch` pulses together with `rsp_valid` for exactly the matched writes whose byte span covers 0x04 or 0x05. It stays low for reads, for misses, and for writes elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus, device/function and offset |
| req_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| req_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, little-endian |
| cmd_touch | output | 1 | Command register was written |

## Verification
The bench builds the block with BAR0 as a 16-byte I/O region, BAR1 as a 4 KiB memory region, BARs 2–5 absent and a 2 KiB ROM. This puts the I/O type bit, the memory case, the absent-register case and the ROM enable bit all in one build. Because the header has only 256 offsets, the bench sweeps every offset for the reset image, for byte writes and for word and dword reads, including the fallback offsets 0xFD–0xFF. Sizing writes and unaligned dword writes inside a BAR check the masking against values the bench computes arithmetically from the region sizes.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int OFF_W      = 8;
  localparam int SEL_W      = 8;
  localparam int CFG_ADDR_W = OFF_W + 2 * SEL_W;
  localparam int HDR_BYTES  = 1 << OFF_W;
  localparam int NUM_BAR    = 6;
  localparam int NUM_SLOT   = NUM_BAR + 1;
  localparam int LOG2_W     = 6;

  localparam logic [7:0] BAR_FIRST_OFF = 8'h10;
  localparam logic [7:0] ROM_REG_OFF   = 8'h30;
  localparam logic [7:0] CMD_LO_OFF    = 8'h04;
  localparam logic [7:0] CMD_HI_OFF    = 8'h05;
  localparam logic [7:0] CMD_HI_KEEP   = 8'h07;
  localparam logic [7:0] HDR_TYPE_VAL  = 8'h00;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_WORD  = 2'd1,
    ACC_DWORD = 2'd2,
    ACC_WIDE  = 2'd3
  } acc_size_e;

  function automatic logic [2:0] acc_len(input logic [1:0] sz);
    case (acc_size_e'(sz))
      ACC_BYTE: return 3'd1;
      ACC_WORD: return 3'd2;
      default:  return 3'd4;
    endcase
  endfunction

  // Bytes that generic writes may not change in a type-0 header.
  function automatic logic byte_locked(input logic [7:0] o);
    return (o == 8'h3D) ||
           (o >= 8'h2C && o <= 8'h33) ||
           (o >= 8'h10 && o <= 8'h27) ||
           (o == 8'h0E) ||
           (o >= 8'h06 && o <= 8'h0B) ||
           (o <= 8'h03);
  endfunction

  function automatic logic [7:0] slot_offset(input int s);
    if (s < NUM_BAR) return BAR_FIRST_OFF + 8'(4 * s);
    return ROM_REG_OFF;
  endfunction
endpackage

// File: rtl/cfg_addr_match.sv
module cfg_addr_match import cfg_hdr_pkg::*; #(
  parameter logic [SEL_W-1:0] BUS_NUM = '0,
  parameter logic [SEL_W-1:0] DEVFN   = '0
) (
  input  logic [CFG_ADDR_W-1:0] addr,
  output logic                  hit,
  output logic [OFF_W-1:0]      off
);
  localparam int DF_LSB  = OFF_W;
  localparam int BUS_LSB = OFF_W + SEL_W;

  assign off = addr[OFF_W-1:0];
  assign hit = (addr[BUS_LSB +: SEL_W] == BUS_NUM) &&
               (addr[DF_LSB  +: SEL_W] == DEVFN);
endmodule

// File: rtl/cfg_bar_mask.sv
module cfg_bar_mask import cfg_hdr_pkg::*; #(
  parameter logic [LOG2_W*NUM_BAR-1:0] BAR_LOG2 = '0,
  parameter logic [NUM_BAR-1:0]        BAR_IO   = '0,
  parameter logic [LOG2_W-1:0]         ROM_LOG2 = '0
) (
  input  logic [OFF_W-3:0] dw_idx,
  input  logic [31:0]      wdata,
  output logic             hit,
  output logic [OFF_W-3:0] base_idx,
  output logic [31:0]      value
);
  logic [NUM_SLOT-1:0] slot_hit;
  logic [31:0]         slot_val [NUM_SLOT];

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    localparam logic [7:0] SOFF = slot_offset(s);
    if (s < NUM_BAR) begin : g_bar
      localparam logic [LOG2_W-1:0] K    = BAR_LOG2[LOG2_W*s +: LOG2_W];
      localparam logic [31:0]       KEEP = ~((32'd1 << K) - 32'd1);
      localparam logic              IOF  = BAR_IO[s];
      assign slot_hit[s] = (K != '0) && (dw_idx == SOFF[7:2]);
      assign slot_val[s] = (wdata & KEEP) | {31'd0, IOF};
    end else begin : g_rom
      localparam logic [31:0] KEEP = ~((32'd1 << ROM_LOG2) - 32'd1);
      assign slot_hit[s] = (ROM_LOG2 != '0) && (dw_idx == SOFF[7:2]);
      assign slot_val[s] = wdata & (KEEP | 32'd1);
    end
  end

  always_comb begin
    hit      = |slot_hit;
    value    = '0;
    base_idx = '0;
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (slot_hit[s]) begin
        value    = slot_val[s];
        base_idx = slot_offset(s) >> 2;
      end
    end
  end
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs import cfg_hdr_pkg::*; #(
  parameter logic [SEL_W-1:0]          BUS_NUM    = 8'h03,
  parameter logic [SEL_W-1:0]          DEVFN      = 8'h28,
  parameter logic [15:0]               VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0]               DEVICE_ID  = 16'h7A12,
  parameter logic [7:0]                REVISION   = 8'h05,
  parameter logic [23:0]               CLASS_CODE = 24'h020000,
  parameter logic [15:0]               SUB_VENDOR = 16'hA5C3,
  parameter logic [15:0]               SUB_DEVICE = 16'h3C5A,
  parameter logic [7:0]                INT_PIN    = 8'h01,
  parameter logic [LOG2_W*NUM_BAR-1:0] BAR_LOG2   = {6'd0, 6'd0, 6'd0, 6'd0, 6'd12, 6'd4},
  parameter logic [NUM_BAR-1:0]        BAR_IO     = 6'b000001,
  parameter logic [LOG2_W-1:0]         ROM_LOG2   = 6'd11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [CFG_ADDR_W-1:0] req_addr,
  input  logic [1:0]            req_size,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_rdata,
  output logic                  cmd_touch
);
  logic [7:0] cfg_q [HDR_BYTES];

  function automatic logic [7:0] init_byte(input int o);
    logic [7:0] v;
    case (o)
      'h00: v = VENDOR_ID[7:0];
      'h01: v = VENDOR_ID[15:8];
      'h02: v = DEVICE_ID[7:0];
      'h03: v = DEVICE_ID[15:8];
      'h08: v = REVISION;
      'h09: v = CLASS_CODE[7:0];
      'h0A: v = CLASS_CODE[15:8];
      'h0B: v = CLASS_CODE[23:16];
      'h0E: v = HDR_TYPE_VAL;
      'h2C: v = SUB_VENDOR[7:0];
      'h2D: v = SUB_VENDOR[15:8];
      'h2E: v = SUB_DEVICE[7:0];
      'h2F: v = SUB_DEVICE[15:8];
      'h3D: v = INT_PIN;
      default: v = 8'h00;
    endcase
    for (int b = 0; b < NUM_BAR; b++) begin
      if (o == 'h10 + 4 * b && BAR_LOG2[LOG2_W*b +: LOG2_W] != '0)
        v = {7'd0, BAR_IO[b]};
    end
    return v;
  endfunction

  // Address routing
  logic             hit;
  logic [OFF_W-1:0] off;

  cfg_addr_match #(.BUS_NUM(BUS_NUM), .DEVFN(DEVFN)) u_match (
    .addr (req_addr),
    .hit  (hit),
    .off  (off)
  );

  // BAR / ROM dword path
  logic             bar_hit;
  logic [OFF_W-3:0] bar_idx;
  logic [31:0]      bar_val;

  cfg_bar_mask #(.BAR_LOG2(BAR_LOG2), .BAR_IO(BAR_IO), .ROM_LOG2(ROM_LOG2)) u_bar (
    .dw_idx   (off[OFF_W-1:2]),
    .wdata    (req_wdata),
    .hit      (bar_hit),
    .base_idx (bar_idx),
    .value    (bar_val)
  );

  logic bar_take;
  assign bar_take = bar_hit && req_size[1];

  // Generic byte-wise write filter
  logic [2:0]  wr_len;
  logic [3:0]  lane_en;
  logic [7:0]  wr_idx  [4];
  logic [7:0]  wr_byte [4];
  logic [8:0]  span_end;
  logic        hits_cmd;

  always_comb begin
    wr_len = acc_len(req_size);
    for (int j = 0; j < 4; j++) begin
      logic [8:0] pos;
      pos        = {1'b0, off} + 9'(j);
      wr_idx[j]  = pos[7:0];
      lane_en[j] = (3'(j) < wr_len) && !pos[8] && !byte_locked(pos[7:0]);
      wr_byte[j] = (pos[7:0] == CMD_HI_OFF) ? (req_wdata[8*j +: 8] & CMD_HI_KEEP)
                                            : req_wdata[8*j +: 8];
    end
    span_end = {1'b0, off} + 9'(wr_len);
    hits_cmd = (span_end > {1'b0, CMD_LO_OFF}) && (off <= CMD_HI_OFF);
  end

  // Read path with size fallback near the top of the header
  logic [2:0]  rd_len;
  logic [31:0] rd_data;
  logic [31:0] miss_data;
  logic [31:0] rd_word;

  always_comb begin
    if (req_size[1] && off <= 8'hFC)        rd_len = 3'd4;
    else if (req_size != 2'd0 && off <= 8'hFE) rd_len = 3'd2;
    else                                    rd_len = 3'd1;
    for (int j = 0; j < 4; j++) begin
      rd_data[8*j +: 8] = (3'(j) < rd_len) ? cfg_q[off + 8'(j)] : 8'h00;
      miss_data[8*j +: 8] = (3'(j) < acc_len(req_size)) ? 8'hFF : 8'h00;
    end
    rd_word = hit ? rd_data : miss_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HDR_BYTES; i++) cfg_q[i] <= init_byte(i);
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      cmd_touch <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
      cmd_touch <= req_valid && req_write && hit && hits_cmd;
      if (req_valid && req_write && hit) begin
        if (bar_take) begin
          for (int j = 0; j < 4; j++) cfg_q[{bar_idx, 2'(j)}] <= bar_val[8*j +: 8];
        end else begin
          for (int j = 0; j < 4; j++) if (lane_en[j]) cfg_q[wr_idx[j]] <= wr_byte[j];
        end
      end
    end
  end

  // Assertions
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R1
  AST_MISS_ONES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !hit) |=> (rsp_rdata[7:0] == 8'hFF)); // R2
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_rdata == 32'd0)); // R3
  AST_VENDOR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable({cfg_q[1], cfg_q[0]})); // R5
  AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[CMD_HI_OFF] & ~CMD_HI_KEEP) == 8'h00); // R6
  AST_TOUCH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd_touch |-> $past(req_valid && req_write && hit)); // R10

  for (genvar b = 0; b < NUM_BAR; b++) begin : g_bar_chk
    localparam logic [LOG2_W-1:0] K   = BAR_LOG2[LOG2_W*b +: LOG2_W];
    localparam logic              IOF = BAR_IO[b];
    localparam int                BOFF = 'h10 + 4 * b;
    if (K != '0) begin : g_impl
      AST_BAR_TYPE_BIT: assert property (@(posedge clk) disable iff (rst)
        cfg_q[BOFF][0] == IOF); // R8
    end
  end
endmodule

// File: tb/cfg_hdr_regs_bench.sv
module cfg_hdr_regs_bench;
  localparam logic [7:0]  BUS   = 8'h03;
  localparam logic [7:0]  DFN   = 8'h28;
  localparam logic [15:0] VID   = 16'h1D0F;
  localparam logic [15:0] DID   = 16'h7A12;
  localparam logic [7:0]  REV   = 8'h05;
  localparam logic [23:0] CLS   = 24'h020000;
  localparam logic [15:0] SVID  = 16'hA5C3;
  localparam logic [15:0] SDID  = 16'h3C5A;
  localparam logic [7:0]  IPIN  = 8'h01;
  localparam int          K0 = 4, K1 = 12, KR = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        cmd_touch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [256];

  always #2 clk = ~clk;

  cfg_hdr_regs #(
    .BUS_NUM(BUS), .DEVFN(DFN), .VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV),
    .CLASS_CODE(CLS), .SUB_VENDOR(SVID), .SUB_DEVICE(SDID), .INT_PIN(IPIN),
    .BAR_LOG2({6'd0, 6'd0, 6'd0, 6'd0, 6'd12, 6'd4}), .BAR_IO(6'b000001), .ROM_LOG2(6'd11)
  ) u_cfg_hdr_regs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cmd_touch(cmd_touch)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic ro_byte(input int o);
    return (o <= 3) || (o >= 6 && o <= 11) || o == 14 || (o >= 16 && o <= 39) ||
           (o >= 44 && o <= 51) || o == 61;
  endfunction

  task automatic model_reset();
    for (int o = 0; o < 256; o++) exp_q[o] = 8'h00;
    exp_q[0] = VID[7:0];  exp_q[1] = VID[15:8];
    exp_q[2] = DID[7:0];  exp_q[3] = DID[15:8];
    exp_q[8] = REV;
    exp_q[9] = CLS[7:0];  exp_q[10] = CLS[15:8]; exp_q[11] = CLS[23:16];
    exp_q[44] = SVID[7:0]; exp_q[45] = SVID[15:8];
    exp_q[46] = SDID[7:0]; exp_q[47] = SDID[15:8];
    exp_q[61] = IPIN;
    exp_q[16] = 8'h01;
  endtask

  task automatic model_write(input int o, input logic [1:0] sz, input logic [31:0] wd);
    int ln;
    logic [31:0] v;
    int base;
    ln = len_of(sz);
    base = -1;
    if (ln == 4 && o >= 16 && o <= 23) begin
      base = 16; v = wd / (1 << K0) * (1 << K0) + 1;
    end else if (ln == 4 && o >= 20 && o <= 23) begin
      base = 20;
    end
    if (ln == 4 && o >= 20 && o <= 23) begin
      base = 20; v = wd / (1 << K1) * (1 << K1);
    end
    if (ln == 4 && o >= 48 && o <= 51) begin
      base = 48; v = wd / (1 << KR) * (1 << KR) + {31'd0, wd[0]};
    end
    if (base >= 0) begin
      for (int j = 0; j < 4; j++) exp_q[base + j] = v[8*j +: 8];
    end else begin
      for (int j = 0; j < ln; j++) begin
        if (o + j <= 255 && !ro_byte(o + j))
          exp_q[o + j] = (o + j == 5) ? (wd[8*j +: 8] & 8'h07) : wd[8*j +: 8];
      end
    end
  endtask

  function automatic logic [31:0] model_read(input int o, input logic [1:0] sz);
    int ln;
    logic [31:0] v;
    ln = (sz >= 2 && o <= 252) ? 4 : (sz != 0 && o <= 254) ? 2 : 1;
    v = '0;
    for (int j = 0; j < ln; j++) v[8*j +: 8] = exp_q[o + j];
    return v;
  endfunction

  task automatic xfer(input logic wr, input logic [7:0] bus, input logic [7:0] dfn,
                      input logic [7:0] o, input logic [1:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output logic tch, output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {bus, dfn, o};
    req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = rsp_rdata; tch = cmd_touch; vld = rsp_valid;
  endtask

  task automatic do_write(input int o, input logic [1:0] sz, input logic [31:0] wd,
                          input string tag);
    logic [31:0] rd; logic t, v;
    int ln;
    ln = len_of(sz);
    xfer(1'b1, BUS, DFN, 8'(o), sz, wd, rd, t, v);
    model_write(o, sz, wd);
    check({tag, " R10 cmd_touch"}, {31'd0, t}, {31'd0, (o <= 5 && o + ln > 4)});
  endtask

  task automatic do_read(input int o, input logic [1:0] sz, input string tag);
    logic [31:0] rd; logic t, v;
    xfer(1'b0, BUS, DFN, 8'(o), sz, 32'h0, rd, t, v);
    check($sformatf("%s off=%h sz=%0d", tag, o, sz), rd, model_read(o, sz));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic t, v;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    check("R10 cmd_touch in reset", {31'd0, cmd_touch}, 32'd0);
    @(negedge clk); rst = 1'b0;
    check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

    // R4: reset image, every offset
    for (int o = 0; o < 256; o++) do_read(o, 2'd0, "R4 reset byte");

    // R1: response one cycle later
    xfer(1'b0, BUS, DFN, 8'h00, 2'd2, 32'h0, rd, t, v);
    check("R1 rsp_valid", {31'd0, v}, 32'd1);
    check("R3 vendor/device dword", rd, {DID, VID});

    // R2: misses on bus and on device/function
    for (int s = 0; s < 4; s++) begin
      xfer(1'b0, BUS ^ 8'h01, DFN, 8'h00, 2'(s), 32'h0, rd, t, v);
      check($sformatf("R2 bus miss sz=%0d", s), rd,
            (s == 0) ? 32'h000000FF : (s == 1) ? 32'h0000FFFF : 32'hFFFFFFFF);
      xfer(1'b0, BUS, DFN ^ 8'h08, 8'h40, 2'(s), 32'h0, rd, t, v);
      check($sformatf("R2 devfn miss sz=%0d", s), rd,
            (s == 0) ? 32'h000000FF : (s == 1) ? 32'h0000FFFF : 32'hFFFFFFFF);
    end

    // R5 R6 R7: byte write sweep over every offset
    for (int o = 0; o < 256; o++) do_write(o, 2'd0, {24'd0, 8'(o) ^ 8'h5A}, "R5 sweep");
    for (int o = 0; o < 256; o++) do_read(o, 2'd0, "R5 R6 after sweep");

    // R2: missed writes change nothing
    xfer(1'b1, BUS ^ 8'h80, DFN, 8'h3C, 2'd2, 32'hDEADBEEF, rd, t, v);
    check("R2 miss write touch", {31'd0, t}, 32'd0);
    xfer(1'b1, BUS, DFN ^ 8'h01, 8'h04, 2'd0, 32'h000000FF, rd, t, v);
    check("R10 miss write no touch", {31'd0, t}, 32'd0);
    do_read(8'h3C, 2'd2, "R2 after miss write");
    do_read(8'h04, 2'd1, "R2 command after miss write");

    // R3: word and dword reads at every offset, incl. fallback at 0xFD..0xFF
    for (int o = 0; o < 256; o++) do_read(o, 2'd1, "R3 word");
    for (int o = 0; o < 256; o++) do_read(o, 2'(2 + (o & 1)), "R3 dword");
    xfer(1'b0, BUS, DFN, 8'hFF, 2'd2, 32'h0, rd, t, v);
    check("R3 dword at 0xFF is byte", rd, {24'd0, exp_q[255]});

    // R3: write response carries zero data
    xfer(1'b1, BUS, DFN, 8'h40, 2'd2, 32'h11223344, rd, t, v);
    model_write(8'h40, 2'd2, 32'h11223344);
    check("R3 write rsp data", rd, 32'd0);
    do_read(8'h40, 2'd2, "R7 dword write");

    // R7: no wrap past 0xFF
    do_write(8'hFD, 2'd2, 32'hAABBCCDD, "R7 tail");
    do_read(8'hFD, 2'd1, "R7 tail word");
    do_read(8'hFF, 2'd0, "R7 tail byte");
    do_read(8'h00, 2'd2, "R7 no wrap to 0x00");

    // R8: BAR sizing and masking
    do_write(8'h10, 2'd2, 32'hFFFFFFFF, "R8 bar0 size");
    check("R8 bar0 all ones", model_read(16, 2'd2), 32'hFFFFFFF1);
    do_read(8'h10, 2'd2, "R8 bar0 readback");
    do_write(8'h14, 2'd2, 32'hFFFFFFFF, "R8 bar1 size");
    do_read(8'h14, 2'd2, "R8 bar1 readback");
    do_write(8'h18, 2'd2, 32'hFFFFFFFF, "R8 bar2 absent");
    do_read(8'h18, 2'd2, "R8 bar2 readback");
    do_write(8'h12, 2'd2, 32'h12345678, "R8 unaligned bar0");
    xfer(1'b0, BUS, DFN, 8'h10, 2'd2, 32'h0, rd, t, v);
    check("R8 unaligned bar0 value", rd, 32'h12345671);
    do_write(8'h11, 2'd0, 32'h000000FF, "R8 byte to bar0");
    do_read(8'h10, 2'd2, "R8 byte write ignored");
    do_write(8'h16, 2'd1, 32'h0000FFFF, "R8 word to bar1");
    do_read(8'h14, 2'd2, "R8 word write ignored");

    // R9: ROM register
    do_write(8'h30, 2'd2, 32'hFFFFFFFF, "R9 rom size");
    xfer(1'b0, BUS, DFN, 8'h30, 2'd2, 32'h0, rd, t, v);
    check("R9 rom all ones", rd, 32'hFFFFF801);
    do_write(8'h31, 2'd3, 32'h0000ABCE, "R9 rom enable clear");
    xfer(1'b0, BUS, DFN, 8'h30, 2'd2, 32'h0, rd, t, v);
    check("R9 rom enable off", rd, 32'h0000A800);

    // R10 R6: spans around the command register
    do_write(8'h03, 2'd1, 32'h0000FF00, "R10 word at 0x03");
    do_write(8'h05, 2'd1, 32'h0000FFFF, "R10 word at 0x05");
    do_read(8'h04, 2'd1, "R6 command word");
    do_write(8'h06, 2'd2, 32'hFFFFFFFF, "R10 dword at 0x06");
    do_write(8'h01, 2'd2, 32'hFFFFFFFF, "R10 dword at 0x01");
    xfer(1'b0, BUS, DFN, 8'h04, 2'd0, 32'h0, rd, t, v);
    check("R10 read no touch", {31'd0, t}, 32'd0);
    do_read(8'h00, 2'd2, "R5 ids after spans");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule